// File: doc/BRIEF.md
# Width-Converting DMA Byte Buffer with Parity

This block sits between a 16-bit DMA port and an 8-bit byte port on the bus side. It holds command, data, status and message bytes while they are in transit. A direction input decides which way bytes move. When it is high, the DMA side writes 16-bit words and the byte side drains them one byte at a time, low byte first. When it is low, the byte side writes single bytes and the DMA side reads them packed into 16-bit words. A final odd byte can be drained on request.

Each byte carries one odd-parity bit. The parity mode input selects between two behaviours. In generate mode, parity on incoming DMA words is checked against the data and all outgoing parity is recomputed. In pass mode, the parity bit stored with each byte is delivered untouched. A burst request tells the DMA engine when a burst of 8 bytes can run without stalling. A one-cycle flush input empties the buffer.

All four data interfaces use valid/ready. A transfer happens on a clock edge where both are high. An offer that is not taken keeps its valid high and its data unchanged until it is taken. Two exceptions apply: a flush, or a change of direction. A DMA read offer made through the tail-drain path may be withdrawn, or widened to a full word, as bytes arrive. A flush forces every ready and valid low in its own cycle, so no handshake is lost to it.

Top module: `wc_dma_fifo`

## Requirements
- R1: After reset, byte_count is 0, empty is 1, full is 0 and par_err is 0.
- R2: With xfer_out=1, dma_wr_ready is high only when at least 2 bytes are free. Each accepted word is split into two bytes. Bits 7:0 go out on scsi_rd_data before bits 15:8.
- R3: With xfer_out=0, each accepted byte-side byte is packed. The earlier byte appears in dma_rd_data bits 7:0 and the later byte in bits 15:8. dma_rd_valid is low while fewer than 2 bytes are held and tail_drain is low.
- R4: With xfer_out=0, exactly 1 byte held and tail_drain=1, dma_rd_valid is high. dma_rd_data is {8'h00, byte}, and one handshake removes that byte.
- R5: An output offer with valid high and ready low keeps valid high and its data stable on the next cycle.
- R6: byte_count equals bytes held (0 to 16). It rises by 2 per accepted DMA word and by 1 per accepted byte-side byte, and falls by 1 per byte-side read. full is high exactly at 16 and empty exactly at 0.
- R7: burst_req is high when (16 - byte_count) >= 8 with xfer_out=1, and when byte_count >= 8 with xfer_out=0.
- R8: With par_gen=1, scsi_rd_par and each dma_rd_par bit are the odd parity of their byte (ones in byte plus bit is odd). dma_rd_par bit 0 covers bits 7:0. An accepted DMA word whose dma_wr_par differs from its odd parity sets par_err.
- R9: With par_gen=0, the parity bit given with each byte is delivered unchanged with that byte, and par_err is not set.
- R10: par_err stays high until perr_clr is high. When a new error and perr_clr arrive in the same cycle, par_err stays high.
- R11: flush=1 drops all readies and valids that cycle and leaves byte_count 0 and empty 1 on the next cycle.
- R12: With xfer_out=0, scsi_wr_ready is high exactly while fewer than 16 bytes are held, and every accepted byte adds one entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| xfer_out | input | 1 | 1: DMA to byte side, 0: byte side to DMA |
| par_gen | input | 1 | 1: generate/check parity, 0: pass parity through |
| flush | input | 1 | Synchronous empty |
| tail_drain | input | 1 | Permit a DMA read of a single last byte |
| perr_clr | input | 1 | Clear the sticky parity error |
| dma_wr_valid | input | 1 | DMA word offered |
| dma_wr_ready | output | 1 | DMA word accepted |
| dma_wr_data | input | 16 | DMA word in |
| dma_wr_par | input | 2 | Parity of the word in, bit 0 for bits 7:0 |
| dma_rd_valid | output | 1 | DMA word offered |
| dma_rd_ready | input | 1 | DMA word taken |
| dma_rd_data | output | 16 | DMA word out |
| dma_rd_par | output | 2 | Parity of the word out |
| scsi_wr_valid | input | 1 | Byte offered |
| scsi_wr_ready | output | 1 | Byte accepted |
| scsi_wr_data | input | 8 | Byte in |
| scsi_wr_par | input | 1 | Parity of the byte in |
| scsi_rd_valid | output | 1 | Byte offered |
| scsi_rd_ready | input | 1 | Byte taken |
| scsi_rd_data | output | 8 | Byte out |
| scsi_rd_par | output | 1 | Parity of the byte out |
| byte_count | output | 5 | Bytes held |
| full | output | 1 | 16 bytes held |
| empty | output | 1 | No byte held |
| burst_req | output | 1 | A burst of 8 can proceed |
| par_err | output | 1 | Sticky parity error |

## Verification
Words are sent through the split path with a table of values. Each entry pairs a data pattern with a parity pair that is either correct or deliberately wrong, and runs in both parity modes. Asymmetric bytes such as 12/34 show whether the low byte leaves first. A wrong parity pair separates recomputed parity from forwarded parity, and also separates the error flag firing in generate mode from staying quiet in pass mode. Directed runs then cover the following:
- a fill to 16 with the burst threshold crossed;
- a stalled byte offer;
- packing of three bytes in pass mode and of two in generate mode;
- the odd tail through the tail-drain path;
- a full packing buffer;
- flush gating;
- the case where a parity error and a clear arrive together.

// File: rtl/wc_pkg.sv
package wc_pkg;
  localparam int BYTE_W = 8;
  localparam int LANES  = 2;

  typedef struct packed {
    logic              par;
    logic [BYTE_W-1:0] data;
  } lane_t;

  function automatic logic odd_par(input logic [BYTE_W-1:0] b);
    return ~^b;
  endfunction
endpackage

// File: rtl/wc_parity.sv
module wc_parity import wc_pkg::*; #(
  parameter int NL = 2
) (
  input  logic [NL*BYTE_W-1:0] data,
  output logic [NL-1:0]        calc
);
  for (genvar g = 0; g < NL; g++) begin : g_lane
    assign calc[g] = odd_par(data[g*BYTE_W +: BYTE_W]);
  end
endmodule

// File: rtl/wc_store.sv
module wc_store import wc_pkg::*; #(
  parameter  int DEPTH = 16,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic                   clk,
  input  logic [LANES-1:0]       we,
  input  logic [AW-1:0]          wptr,
  input  lane_t [LANES-1:0]      wlane,
  input  logic [AW-1:0]          rptr,
  output lane_t [LANES-1:0]      rlane
);
  lane_t mem [DEPTH];

  always_ff @(posedge clk) begin
    for (int i = 0; i < LANES; i++)
      if (we[i]) mem[AW'(wptr + AW'(i))] <= wlane[i];
  end

  for (genvar g = 0; g < LANES; g++) begin : g_rd
    assign rlane[g] = mem[AW'(rptr + AW'(g))];
  end
endmodule

// File: rtl/wc_ctrl.sv
module wc_ctrl #(
  parameter  int DEPTH = 16,
  localparam int AW    = $clog2(DEPTH),
  localparam int CW    = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic [1:0]    push_n,
  input  logic [1:0]    pop_n,
  output logic [AW-1:0] wptr,
  output logic [AW-1:0] rptr,
  output logic [CW-1:0] cnt
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr <= '0;
      rptr <= '0;
      cnt  <= '0;
    end else if (flush) begin
      wptr <= '0;
      rptr <= '0;
      cnt  <= '0;
    end else begin
      wptr <= AW'(wptr + AW'(push_n));
      rptr <= AW'(rptr + AW'(pop_n));
      cnt  <= CW'(cnt + CW'(push_n) - CW'(pop_n));
    end
  end
endmodule

// File: rtl/wc_dma_fifo.sv
module wc_dma_fifo import wc_pkg::*; #(
  parameter  int DEPTH = 16,
  parameter  int BURST = 8,
  localparam int AW    = $clog2(DEPTH),
  localparam int CW    = AW + 1,
  localparam int WW    = LANES * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              xfer_out,
  input  logic              par_gen,
  input  logic              flush,
  input  logic              tail_drain,
  input  logic              perr_clr,
  input  logic              dma_wr_valid,
  output logic              dma_wr_ready,
  input  logic [WW-1:0]     dma_wr_data,
  input  logic [LANES-1:0]  dma_wr_par,
  output logic              dma_rd_valid,
  input  logic              dma_rd_ready,
  output logic [WW-1:0]     dma_rd_data,
  output logic [LANES-1:0]  dma_rd_par,
  input  logic              scsi_wr_valid,
  output logic              scsi_wr_ready,
  input  logic [BYTE_W-1:0] scsi_wr_data,
  input  logic              scsi_wr_par,
  output logic              scsi_rd_valid,
  input  logic              scsi_rd_ready,
  output logic [BYTE_W-1:0] scsi_rd_data,
  output logic              scsi_rd_par,
  output logic [CW-1:0]     byte_count,
  output logic              full,
  output logic              empty,
  output logic              burst_req,
  output logic              par_err
);
  logic [AW-1:0]        wptr, rptr;
  logic [CW-1:0]        cnt, free_b;
  logic [1:0]           push_n, pop_n;
  logic [LANES-1:0]     we;
  lane_t [LANES-1:0]    wlane, rlane;
  logic                 two_avail;
  logic                 dma_wr_fire, dma_rd_fire, scsi_wr_fire, scsi_rd_fire;
  logic [LANES-1:0]     in_calc, out_calc;
  logic [0:0]           s_calc;
  logic [WW-1:0]        dma_src_data;
  logic [LANES-1:0]     dma_src_par;

  assign free_b    = CW'(DEPTH) - cnt;
  assign two_avail = cnt >= CW'(LANES);

  // handshake gating: flush blocks every transfer in its cycle
  assign dma_wr_ready  = xfer_out  & ~flush & (free_b >= CW'(LANES));
  assign scsi_rd_valid = xfer_out  & ~flush & (cnt != '0);
  assign scsi_wr_ready = ~xfer_out & ~flush & (cnt != CW'(DEPTH));
  assign dma_rd_valid  = ~xfer_out & ~flush &
                         (two_avail | (tail_drain & (cnt == CW'(1))));

  assign dma_wr_fire  = dma_wr_valid  & dma_wr_ready;
  assign scsi_rd_fire = scsi_rd_valid & scsi_rd_ready;
  assign scsi_wr_fire = scsi_wr_valid & scsi_wr_ready;
  assign dma_rd_fire  = dma_rd_valid  & dma_rd_ready;

  always_comb begin
    wlane  = '0;
    we     = '0;
    push_n = 2'd0;
    pop_n  = 2'd0;
    if (xfer_out) begin
      for (int i = 0; i < LANES; i++) begin
        wlane[i].data = dma_wr_data[i*BYTE_W +: BYTE_W];
        wlane[i].par  = dma_wr_par[i];
      end
      we     = {LANES{dma_wr_fire}};
      push_n = dma_wr_fire ? 2'(LANES) : 2'd0;
      pop_n  = {1'b0, scsi_rd_fire};
    end else begin
      wlane[0].data = scsi_wr_data;
      wlane[0].par  = scsi_wr_par;
      we[0]  = scsi_wr_fire;
      push_n = {1'b0, scsi_wr_fire};
      pop_n  = dma_rd_fire ? (two_avail ? 2'(LANES) : 2'd1) : 2'd0;
    end
  end

  wc_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .push_n(push_n), .pop_n(pop_n),
    .wptr(wptr), .rptr(rptr), .cnt(cnt)
  );

  wc_store #(.DEPTH(DEPTH)) u_store (
    .clk(clk), .we(we), .wptr(wptr), .wlane(wlane),
    .rptr(rptr), .rlane(rlane)
  );

  // single tail byte: upper lane forced to zero data with odd parity
  always_comb begin
    for (int i = 0; i < LANES; i++) begin
      dma_src_data[i*BYTE_W +: BYTE_W] = (i == 0 || two_avail) ? rlane[i].data : '0;
      dma_src_par[i] = (i == 0 || two_avail) ? rlane[i].par : 1'b1;
    end
  end

  wc_parity #(.NL(LANES)) u_par_in  (.data(dma_wr_data),     .calc(in_calc));
  wc_parity #(.NL(LANES)) u_par_out (.data(dma_src_data),    .calc(out_calc));
  wc_parity #(.NL(1))     u_par_byt (.data(rlane[0].data),   .calc(s_calc));

  assign dma_rd_data  = dma_src_data;
  assign dma_rd_par   = par_gen ? out_calc : dma_src_par;
  assign scsi_rd_data = rlane[0].data;
  assign scsi_rd_par  = par_gen ? s_calc[0] : rlane[0].par;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      par_err <= 1'b0;
    else if (par_gen & dma_wr_fire & (|(in_calc ^ dma_wr_par)))
      par_err <= 1'b1;
    else if (perr_clr)
      par_err <= 1'b0;
  end

  assign byte_count = cnt;
  assign full       = cnt == CW'(DEPTH);
  assign empty      = cnt == '0;
  assign burst_req  = xfer_out ? (free_b >= CW'(BURST)) : (cnt >= CW'(BURST));
endmodule

// File: rtl/wc_dma_fifo_chk.sv
module wc_dma_fifo_chk #(
  parameter  int DEPTH = 16,
  localparam int CW    = $clog2(DEPTH) + 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          xfer_out,
  input logic          flush,
  input logic          tail_drain,
  input logic          perr_clr,
  input logic          dma_wr_valid,
  input logic          dma_wr_ready,
  input logic          dma_rd_valid,
  input logic          dma_rd_ready,
  input logic [15:0]   dma_rd_data,
  input logic          scsi_wr_ready,
  input logic          scsi_rd_valid,
  input logic          scsi_rd_ready,
  input logic [7:0]    scsi_rd_data,
  input logic [CW-1:0] byte_count,
  input logic          full,
  input logic          empty,
  input logic          par_err
);
  p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    byte_count <= CW'(DEPTH));

  p_word_count_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!flush && dma_wr_valid && dma_wr_ready && !(scsi_rd_valid && scsi_rd_ready))
    |=> byte_count == CW'($past(byte_count) + CW'(2)));

  p_wr_room_r2: assert property (@(posedge clk) disable iff (!rst_n)
    dma_wr_ready |-> (CW'(DEPTH) - byte_count) >= CW'(2));

  p_rd_pair_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_rd_valid && !tail_drain) |-> byte_count >= CW'(2));

  p_byte_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (scsi_rd_valid && !scsi_rd_ready) |=>
    (flush || xfer_out != $past(xfer_out) ||
     (scsi_rd_valid && scsi_rd_data == $past(scsi_rd_data))));

  p_word_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_rd_valid && !dma_rd_ready && byte_count >= CW'(2)) |=>
    (flush || xfer_out != $past(xfer_out) ||
     (dma_rd_valid && dma_rd_data == $past(dma_rd_data))));

  p_flush_empty_r11: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (byte_count == '0 && empty));

  p_err_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (par_err && !perr_clr) |=> par_err);

  p_full_block_r12: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> (!scsi_wr_ready && !dma_wr_ready));
endmodule

bind wc_dma_fifo wc_dma_fifo_chk #(.DEPTH(DEPTH)) u_chk (.*);

// File: tb/sim_wc_dma_fifo.sv
module sim_wc_dma_fifo;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, xfer_out, par_gen, flush, tail_drain, perr_clr;
  logic dma_wr_valid, dma_wr_ready, dma_rd_valid, dma_rd_ready;
  logic [15:0] dma_wr_data, dma_rd_data;
  logic [1:0]  dma_wr_par, dma_rd_par;
  logic scsi_wr_valid, scsi_wr_ready, scsi_wr_par;
  logic scsi_rd_valid, scsi_rd_ready, scsi_rd_par;
  logic [7:0] scsi_wr_data, scsi_rd_data;
  logic [4:0] byte_count;
  logic full, empty, burst_req, par_err;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  wc_dma_fifo u0 (.*);

  function automatic logic op(input logic [7:0] b);
    return ~^b;
  endfunction

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string what);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  // {par_gen, par[1:0], data[15:0]}
  localparam logic [18:0] VEC [6] = '{
    {1'b1, 2'b10, 16'h1234}, {1'b1, 2'b00, 16'h00FF}, {1'b0, 2'b01, 16'hA55A},
    {1'b0, 2'b11, 16'h8001}, {1'b1, 2'b11, 16'hFFFF}, {1'b0, 2'b00, 16'h7E81}
  };

  task automatic push_byte(input logic [7:0] d, input logic p, input string tag);
    @(negedge clk);
    scsi_wr_valid = 1; scsi_wr_data = d; scsi_wr_par = p;
    #1 check(scsi_wr_ready, 1, tag);
    @(negedge clk);
    scsi_wr_valid = 0;
  endtask

  task automatic pulse_flush;
    @(negedge clk); flush = 1;
    @(negedge clk); flush = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 0; xfer_out = 1; par_gen = 1; flush = 0; tail_drain = 0; perr_clr = 0;
    dma_wr_valid = 0; dma_wr_data = 0; dma_wr_par = 0; dma_rd_ready = 0;
    scsi_wr_valid = 0; scsi_wr_data = 0; scsi_wr_par = 0; scsi_rd_ready = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(byte_count, 0, "R1 count");
    check(empty, 1, "R1 empty");
    check(full, 0, "R1 full");
    check(par_err, 0, "R1 par_err");
    check(burst_req, 1, "R7 burst at empty outbound");

    // table walk: split path, both parity modes
    for (int v = 0; v < 6; v++) begin
      logic pg; logic [1:0] pr; logic [15:0] d; logic e_err; logic pl, ph;
      string pt;
      {pg, pr, d} = VEC[v];
      e_err = pg && (pr != {op(d[15:8]), op(d[7:0])});
      pl = pg ? op(d[7:0])  : pr[0];
      ph = pg ? op(d[15:8]) : pr[1];
      pt = pg ? "R8" : "R9";
      @(negedge clk); perr_clr = 1; par_gen = pg;
      @(negedge clk); perr_clr = 0;
      dma_wr_valid = 1; dma_wr_data = d; dma_wr_par = pr;
      #1 check(dma_wr_ready, 1, "R2 ready with room");
      @(negedge clk); dma_wr_valid = 0;
      check(byte_count, 2, "R6 count after word");
      check(par_err, e_err, {pt, " error flag"});
      scsi_rd_ready = 1;
      #1 check(scsi_rd_data, d[7:0], "R2 low byte first");
      check(scsi_rd_par, pl, {pt, " low parity"});
      @(negedge clk);
      check(scsi_rd_data, d[15:8], "R2 high byte second");
      check(scsi_rd_par, ph, {pt, " high parity"});
      @(negedge clk); scsi_rd_ready = 0;
      check(empty, 1, "R6 empty after two reads");
    end

    // fill to full, burst threshold
    @(negedge clk); perr_clr = 1; par_gen = 0;
    @(negedge clk); perr_clr = 0;
    for (int i = 0; i < 8; i++) begin
      check(burst_req, (16 - 2 * i) >= 8, "R7 outbound threshold");
      dma_wr_valid = 1; dma_wr_data = {8'(2 * i + 1), 8'(2 * i)}; dma_wr_par = 2'b01;
      #1 check(dma_wr_ready, 1, "R2 ready before full");
      @(negedge clk);
    end
    dma_wr_valid = 1; dma_wr_data = 16'hDEAD;
    #1 check(dma_wr_ready, 0, "R2 no room at 16");
    check(full, 1, "R6 full");
    check(byte_count, 16, "R6 count 16");
    @(negedge clk); dma_wr_valid = 0;
    check(byte_count, 16, "R2 word refused");
    for (int k = 0; k < 3; k++) begin
      check(scsi_rd_valid, 1, "R5 offer held");
      check(scsi_rd_data, 8'h00, "R5 data held");
      @(negedge clk);
    end
    scsi_rd_ready = 1;
    for (int k = 0; k < 3; k++) begin
      #1 check(scsi_rd_data, 8'(k), "R2 byte order");
      @(negedge clk);
    end
    scsi_rd_ready = 0;
    check(byte_count, 13, "R6 count after reads");
    flush = 1;
    #1 check(scsi_rd_valid, 0, "R11 valid gated");
    check(dma_wr_ready, 0, "R11 ready gated");
    @(negedge clk); flush = 0;
    check(byte_count, 0, "R11 count cleared");
    check(empty, 1, "R11 empty");

    // packing, pass mode
    xfer_out = 0; par_gen = 0;
    #1 check(burst_req, 0, "R7 inbound empty");
    push_byte(8'hA1, 1'b0, "R12 ready");
    check(dma_rd_valid, 0, "R3 one byte no word");
    push_byte(8'hB2, 1'b1, "R12 ready");
    push_byte(8'hC3, 1'b1, "R12 ready");
    check(dma_rd_valid, 1, "R3 word ready");
    check(dma_rd_data, 16'hB2A1, "R3 first byte low");
    check(dma_rd_par, 2'b10, "R9 parity forwarded");
    dma_rd_ready = 1;
    @(negedge clk); dma_rd_ready = 0;
    check(byte_count, 1, "R6 count after word read");
    check(dma_rd_valid, 0, "R3 lone byte held");
    tail_drain = 1;
    #1 check(dma_rd_valid, 1, "R4 tail offered");
    check(dma_rd_data, 16'h00C3, "R4 tail data");
    check(dma_rd_par, 2'b11, "R4 tail parity");
    dma_rd_ready = 1;
    @(negedge clk); dma_rd_ready = 0; tail_drain = 0;
    check(empty, 1, "R4 tail removed");

    // packing, generate mode
    par_gen = 1;
    push_byte(8'h07, 1'b0, "R12 ready");
    push_byte(8'h03, 1'b0, "R12 ready");
    check(dma_rd_data, 16'h0307, "R3 packing");
    check(dma_rd_par, {op(8'h03), op(8'h07)}, "R8 parity recomputed");
    check(par_err, 0, "R8 no error from byte side");
    dma_rd_ready = 1;
    @(negedge clk); dma_rd_ready = 0;
    check(empty, 1, "R6 empty");

    // inbound fill
    for (int i = 0; i < 16; i++) begin
      check(burst_req, i >= 8, "R7 inbound threshold");
      push_byte(8'(i + 8'h40), 1'b0, "R12 ready below full");
    end
    check(full, 1, "R12 full");
    scsi_wr_valid = 1;
    #1 check(scsi_wr_ready, 0, "R12 refused when full");
    @(negedge clk); scsi_wr_valid = 0;
    check(byte_count, 16, "R12 count unchanged");
    check(dma_rd_data, 16'h4140, "R3 fill order");
    pulse_flush();

    // sticky error
    xfer_out = 1; par_gen = 1;
    @(negedge clk);
    dma_wr_valid = 1; dma_wr_data = 16'h0000; dma_wr_par = 2'b00;
    @(negedge clk); dma_wr_valid = 0;
    check(par_err, 1, "R8 bad parity flagged");
    repeat (3) @(negedge clk);
    check(par_err, 1, "R10 error held");
    perr_clr = 1;
    @(negedge clk); perr_clr = 0;
    check(par_err, 0, "R10 error cleared");
    dma_wr_valid = 1; dma_wr_par = 2'b01; perr_clr = 1;
    @(negedge clk); dma_wr_valid = 0; perr_clr = 0;
    check(par_err, 1, "R10 set wins over clear");
    pulse_flush();

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule